// File: doc/BRIEF.md
# Display-Identification Block Fetch Engine

This engine sits between a register port and a byte-level I2C master. It fetches one 128-byte display-identification block from a monitor's DDC bus into a local buffer. Software picks a block number and starts the fetch. The engine then splits the block number into a segment pointer (block number halved) and a byte offset (0 for an even block, 128 for an odd one). If the segment is nonzero, the engine first writes the segment pointer to the segment-pointer device. It then writes the offset to the data device and reads the 128 bytes back through a repeated start. The bytes land in the buffer in order.

Completion is reported through a sticky flag that software clears. A device that fails to acknowledge any written byte ends the fetch early. In that case the engine sends a stop, sets an error flag and still reports completion, so a polling loop never hangs. Both device addresses are registers with the usual defaults. Every fetch issues a bounded number of bus commands.

Top module: `edid_fetch_engine`

## Requirements
- R1: After reset, the register at 0x83 (data device write address) reads 0xA0, the register at 0x84 (segment-pointer device address) reads 0x60, and both the control register 0x80 and the flag register 0x81 read 0.
- R2: A register write to 0x80 with bit 0 set, made while idle, starts a fetch. Flag bit 0 (busy) then reads 1 until the fetch ends.
- R3: A block number B taken from register 0x82 selects segment B>>1 and byte offset 128 when B is odd, 0 when B is even.
- R4: For segment 0 the bus commands are: START, WRITE data address, WRITE offset, START, WRITE data address|1, 128 READs with only the last marked not-acknowledge, STOP. Command op codes are START=0, WRITE=1, READ=2, STOP=3.
- R5: For a nonzero segment, the R4 sequence is preceded by START, WRITE segment-device address and WRITE segment value. The data address then follows a repeated START.
- R6: The n-th byte read (n from 0) is readable at register address n, for 0x00 to 0x7F.
- R7: Completion sets flag bit 1, which stays set. A flag write with bit 1 at 0 clears it. A flag write with bit 1 at 1 does not set it.
- R8: A not-acknowledge on any written byte stops the sequence: the next command is STOP, flag bits 1 and 2 are both set, and the buffer keeps its previous contents. Writing 0 to flag bit 2 clears it.
- R9: A start write made while busy is ignored: no extra commands are issued, and the running fetch uses the block number latched at its own start.
- R10: The engine uses the current values of registers 0x83 and 0x84 as the device addresses on the bus.
- R11: A fetch issues at most 137 commands (128 reads plus 9 others) and ends within a bound set by the bus latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| i2c_cmd_valid | output | 1 | Bus command offered |
| i2c_cmd_ready | input | 1 | Bus master accepts the command |
| i2c_cmd_op | output | 2 | Command op code: START=0, WRITE=1, READ=2, STOP=3 |
| i2c_cmd_data | output | 8 | Byte to write |
| i2c_cmd_nack | output | 1 | Answer this READ with a not-acknowledge |
| i2c_rsp_valid | input | 1 | One response per accepted command |
| i2c_rsp_nack | input | 1 | The written byte was not acknowledged |
| i2c_rsp_data | input | 8 | Byte read |

## Verification
The bench drives fetches of even and odd blocks in segment 0 and in higher segments. A scoreboard compares every bus command, so an engine that swaps the offset parity, always writes the segment pointer, or drops the repeated start shows up at the first wrong command.

A not-acknowledge is injected on the segment-pointer byte and on the read address byte. An engine that keeps going, skips the stop, or overwrites the buffer then fails the command check or the buffer check. A second start during a busy fetch, together with a block-number change, catches an engine that restarts or re-reads its inputs. The flag tests write 1 and 0 to the done and error bits, which catches a flag that is not sticky or that can be set by software.

// File: rtl/edid_fetch_pkg.sv
package edid_fetch_pkg;

    // bus command op codes of the byte-level master
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } i2c_op_e;

    // steps of one fetch
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_A,
        ST_SEG_DEV,
        ST_SEG_PTR,
        ST_START_B,
        ST_DEV_W,
        ST_OFFS,
        ST_START_C,
        ST_DEV_R,
        ST_READ,
        ST_STOP
    } step_e;

    // register map above the buffer window
    localparam logic [7:0] RA_CTRL     = 8'h80;
    localparam logic [7:0] RA_FLAGS    = 8'h81;
    localparam logic [7:0] RA_BLOCK    = 8'h82;
    localparam logic [7:0] RA_DATA_DEV = 8'h83;
    localparam logic [7:0] RA_SEG_DEV  = 8'h84;

    localparam int FLAG_BUSY = 0;
    localparam int FLAG_DONE = 1;
    localparam int FLAG_ERR  = 2;

endpackage

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq
    import edid_fetch_pkg::*;
#(
    parameter int BLK_BYTES = 128,
    localparam int IDX_W = $clog2(BLK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       block_num,
    input  logic [7:0]       data_dev,
    input  logic [7:0]       seg_dev,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output i2c_op_e          cmd_op,
    output logic [7:0]       cmd_data,
    output logic             cmd_nack,
    input  logic             rsp_valid,
    input  logic             rsp_nack,
    input  logic [7:0]       rsp_data,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_idx,
    output logic [7:0]       buf_wdata,
    output logic             busy,
    output logic             done,
    output logic             err
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);
    localparam logic [7:0]       ODD_OFFS = 8'(BLK_BYTES);

    typedef struct packed {
        step_e            step;
        logic             wait_rsp;
        logic [IDX_W-1:0] cnt;
        logic [6:0]       seg;
        logic             odd;
        logic             err;
        logic             done;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        buf_we     = 1'b0;
        buf_idx    = seq_q.cnt;
        buf_wdata  = rsp_data;

        if (seq_q.step == ST_IDLE) begin
            if (go) begin
                seq_d.step     = ST_START_A;
                seq_d.wait_rsp = 1'b0;
                seq_d.cnt      = '0;
                seq_d.seg      = block_num[7:1];
                seq_d.odd      = block_num[0];
                seq_d.err      = 1'b0;
            end
        end else if (!seq_q.wait_rsp) begin
            if (cmd_ready) seq_d.wait_rsp = 1'b1;
        end else if (rsp_valid) begin
            seq_d.wait_rsp = 1'b0;
            unique case (seq_q.step)
                ST_START_A: seq_d.step = (seq_q.seg != '0) ? ST_SEG_DEV : ST_DEV_W;
                ST_START_B: seq_d.step = ST_DEV_W;
                ST_START_C: seq_d.step = ST_DEV_R;
                ST_SEG_DEV: seq_d.step = ST_SEG_PTR;
                ST_SEG_PTR: seq_d.step = ST_START_B;
                ST_DEV_W:   seq_d.step = ST_OFFS;
                ST_OFFS:    seq_d.step = ST_START_C;
                ST_DEV_R:   seq_d.step = ST_READ;
                ST_READ: begin
                    buf_we = 1'b1;
                    if (seq_q.cnt == LAST_IDX) seq_d.step = ST_STOP;
                    else                       seq_d.cnt  = seq_q.cnt + 1'b1;
                end
                ST_STOP: begin
                    seq_d.step = ST_IDLE;
                    seq_d.done = 1'b1;
                end
                default: seq_d.step = ST_IDLE;
            endcase
            // a refused byte on any write step ends the transfer
            if (rsp_nack && (cmd_op == OP_WRITE)) begin
                seq_d.err  = 1'b1;
                seq_d.step = ST_STOP;
            end
        end
    end

    always_comb begin
        cmd_valid = (seq_q.step != ST_IDLE) && !seq_q.wait_rsp;
        cmd_data  = 8'h00;
        cmd_nack  = 1'b0;
        unique case (seq_q.step)
            ST_SEG_DEV: begin cmd_op = OP_WRITE; cmd_data = seg_dev;            end
            ST_SEG_PTR: begin cmd_op = OP_WRITE; cmd_data = {1'b0, seq_q.seg};  end
            ST_DEV_W:   begin cmd_op = OP_WRITE; cmd_data = data_dev;           end
            ST_OFFS:    begin cmd_op = OP_WRITE; cmd_data = seq_q.odd ? ODD_OFFS : 8'h00; end
            ST_DEV_R:   begin cmd_op = OP_WRITE; cmd_data = data_dev | 8'h01;   end
            ST_READ:    begin cmd_op = OP_READ;  cmd_nack = (seq_q.cnt == LAST_IDX); end
            ST_STOP:    cmd_op = OP_STOP;
            default:    cmd_op = OP_START;
        endcase
    end

    assign busy = (seq_q.step != ST_IDLE);
    assign done = seq_q.done;
    assign err  = seq_q.err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

endmodule

// File: rtl/edid_fetch_regs.sv
module edid_fetch_regs
    import edid_fetch_pkg::*;
#(
    parameter int         BLK_BYTES    = 128,
    parameter logic [7:0] DEF_DATA_DEV = 8'hA0,
    parameter logic [7:0] DEF_SEG_DEV  = 8'h60,
    localparam int IDX_W = $clog2(BLK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             seq_busy,
    input  logic             seq_done,
    input  logic             seq_err,
    input  logic             buf_we,
    input  logic [IDX_W-1:0] buf_idx,
    input  logic [7:0]       buf_wdata,
    output logic             go,
    output logic [7:0]       block_num,
    output logic [7:0]       data_dev,
    output logic [7:0]       seg_dev
);

    typedef struct packed {
        logic       ctrl;
        logic       done;
        logic       err;
        logic [7:0] block;
        logic [7:0] data_dev;
        logic [7:0] seg_dev;
    } regs_s;

    regs_s rg_d, rg_q;
    logic [7:0] blk_mem [BLK_BYTES];

    always_comb begin
        rg_d = rg_q;
        go   = 1'b0;
        if (reg_we) begin
            unique case (reg_addr)
                RA_CTRL: begin
                    rg_d.ctrl = reg_wdata[0];
                    go        = reg_wdata[0] && !seq_busy;
                end
                RA_FLAGS: begin
                    rg_d.done = rg_q.done & reg_wdata[FLAG_DONE];
                    rg_d.err  = rg_q.err  & reg_wdata[FLAG_ERR];
                end
                RA_BLOCK:    rg_d.block    = reg_wdata;
                RA_DATA_DEV: rg_d.data_dev = reg_wdata;
                RA_SEG_DEV:  rg_d.seg_dev  = reg_wdata;
                default: ;
            endcase
        end
        if (seq_done) begin
            rg_d.done = 1'b1;
            rg_d.err  = rg_d.err | seq_err;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (!reg_addr[7]) begin
            if ({24'h0, reg_addr} < 32'(BLK_BYTES)) reg_rdata = blk_mem[reg_addr[IDX_W-1:0]];
        end else begin
            unique case (reg_addr)
                RA_CTRL:     reg_rdata = {7'h00, rg_q.ctrl};
                RA_FLAGS:    reg_rdata = {5'h00, rg_q.err, rg_q.done, seq_busy};
                RA_BLOCK:    reg_rdata = rg_q.block;
                RA_DATA_DEV: reg_rdata = rg_q.data_dev;
                RA_SEG_DEV:  reg_rdata = rg_q.seg_dev;
                default:     reg_rdata = 8'h00;
            endcase
        end
    end

    assign block_num = rg_q.block;
    assign data_dev  = rg_q.data_dev;
    assign seg_dev   = rg_q.seg_dev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q          <= '0;
            rg_q.data_dev <= DEF_DATA_DEV;
            rg_q.seg_dev  <= DEF_SEG_DEV;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we) blk_mem[buf_idx] <= buf_wdata;
    end

endmodule

// File: rtl/edid_fetch_engine.sv
module edid_fetch_engine
    import edid_fetch_pkg::*;
#(
    parameter int         BLK_BYTES    = 128,
    parameter logic [7:0] DEF_DATA_DEV = 8'hA0,
    parameter logic [7:0] DEF_SEG_DEV  = 8'h60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       i2c_cmd_valid,
    input  logic       i2c_cmd_ready,
    output logic [1:0] i2c_cmd_op,
    output logic [7:0] i2c_cmd_data,
    output logic       i2c_cmd_nack,
    input  logic       i2c_rsp_valid,
    input  logic       i2c_rsp_nack,
    input  logic [7:0] i2c_rsp_data
);

    localparam int IDX_W = $clog2(BLK_BYTES);

    logic             seq_go;
    logic             seq_busy;
    logic             seq_done;
    logic             seq_err;
    logic [7:0]       block_num;
    logic [7:0]       data_dev;
    logic [7:0]       seg_dev;
    logic             buf_we;
    logic [IDX_W-1:0] buf_idx;
    logic [7:0]       buf_wdata;
    i2c_op_e          seq_op;

    edid_fetch_regs #(
        .BLK_BYTES   (BLK_BYTES),
        .DEF_DATA_DEV(DEF_DATA_DEV),
        .DEF_SEG_DEV (DEF_SEG_DEV)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .seq_busy (seq_busy),
        .seq_done (seq_done),
        .seq_err  (seq_err),
        .buf_we   (buf_we),
        .buf_idx  (buf_idx),
        .buf_wdata(buf_wdata),
        .go       (seq_go),
        .block_num(block_num),
        .data_dev (data_dev),
        .seg_dev  (seg_dev)
    );

    edid_fetch_seq #(
        .BLK_BYTES(BLK_BYTES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (seq_go),
        .block_num(block_num),
        .data_dev (data_dev),
        .seg_dev  (seg_dev),
        .cmd_valid(i2c_cmd_valid),
        .cmd_ready(i2c_cmd_ready),
        .cmd_op   (seq_op),
        .cmd_data (i2c_cmd_data),
        .cmd_nack (i2c_cmd_nack),
        .rsp_valid(i2c_rsp_valid),
        .rsp_nack (i2c_rsp_nack),
        .rsp_data (i2c_rsp_data),
        .buf_we   (buf_we),
        .buf_idx  (buf_idx),
        .buf_wdata(buf_wdata),
        .busy     (seq_busy),
        .done     (seq_done),
        .err      (seq_err)
    );

    assign i2c_cmd_op = seq_op;

endmodule

// File: rtl/edid_fetch_chk.sv
module edid_fetch_chk #(
    parameter int BLK_BYTES = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_addr,
    input logic       ctrl_bit,
    input logic       i2c_cmd_valid,
    input logic       i2c_cmd_ready,
    input logic [1:0] i2c_cmd_op,
    input logic       i2c_rsp_valid,
    input logic       i2c_rsp_nack,
    input logic       seq_go,
    input logic       seq_busy,
    input logic       buf_we
);

    localparam int MAX_CMDS = BLK_BYTES + 9;

    logic [8:0] cmd_cnt;
    logic       last_write;
    logic       nack_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_cnt    <= '0;
            last_write <= 1'b0;
            nack_seen  <= 1'b0;
        end else begin
            if (seq_go) begin
                cmd_cnt   <= '0;
                nack_seen <= 1'b0;
            end else begin
                if (i2c_cmd_valid && i2c_cmd_ready) begin
                    cmd_cnt    <= cmd_cnt + 1'b1;
                    last_write <= (i2c_cmd_op == 2'd1);
                end
                if (i2c_rsp_valid && i2c_rsp_nack && last_write && seq_busy) nack_seen <= 1'b1;
            end
        end
    end

    // R2
    start_from_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> ($past(reg_we) && ($past(reg_addr) == 8'h80) && $past(ctrl_bit)));

    // R2
    cmd_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_cmd_valid |-> seq_busy);

    // R4
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i2c_cmd_valid && i2c_cmd_ready) |=> !i2c_cmd_valid);

    // R6
    buf_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> seq_busy);

    // R8
    stop_after_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_seen && i2c_cmd_valid) |-> (i2c_cmd_op == 2'd3));

    // R11
    cmd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cnt <= 9'(MAX_CMDS));

endmodule

bind edid_fetch_engine edid_fetch_chk #(.BLK_BYTES(BLK_BYTES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .ctrl_bit     (reg_wdata[0]),
    .i2c_cmd_valid(i2c_cmd_valid),
    .i2c_cmd_ready(i2c_cmd_ready),
    .i2c_cmd_op   (i2c_cmd_op),
    .i2c_rsp_valid(i2c_rsp_valid),
    .i2c_rsp_nack (i2c_rsp_nack),
    .seq_go       (seq_go),
    .seq_busy     (seq_busy),
    .buf_we       (buf_we)
);

// File: tb/test_edid_fetch_engine.sv
module test_edid_fetch_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       i2c_cmd_valid;
    logic       i2c_cmd_ready = 1'b1;
    logic [1:0] i2c_cmd_op;
    logic [7:0] i2c_cmd_data;
    logic       i2c_cmd_nack;
    logic       i2c_rsp_valid = 1'b0;
    logic       i2c_rsp_nack = 1'b0;
    logic [7:0] i2c_rsp_data = 8'h00;

    int checks = 0;
    int fails  = 0;

    // scoreboard of expected commands {nack, op, data}
    logic [10:0] exp_q[$];
    int          cmd_seen = 0;

    // bus-side model state
    logic [7:0] m_data_dev = 8'hA0;
    logic [7:0] m_seg_dev  = 8'h60;
    int         nack_at    = -1;
    int         wr_idx     = 0;
    logic       addr_phase = 1'b0;
    logic [7:0] cur_dev    = 8'h00;
    logic [7:0] seg_ptr    = 8'h00;
    logic [7:0] offs       = 8'h00;
    logic       pend       = 1'b0;
    logic       pend_nack  = 1'b0;
    logic [7:0] pend_data  = 8'h00;

    edid_fetch_engine i_edid_fetch_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .i2c_cmd_valid(i2c_cmd_valid),
        .i2c_cmd_ready(i2c_cmd_ready),
        .i2c_cmd_op   (i2c_cmd_op),
        .i2c_cmd_data (i2c_cmd_data),
        .i2c_cmd_nack (i2c_cmd_nack),
        .i2c_rsp_valid(i2c_rsp_valid),
        .i2c_rsp_nack (i2c_rsp_nack),
        .i2c_rsp_data (i2c_rsp_data)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] edid_byte(input logic [7:0] seg, input logic [7:0] a);
        return 8'((int'(seg) * 29) ^ (int'(a) * 7) ^ 8'h5A);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // driver: expected command stream of one fetch
    task automatic expect_fetch(input logic [7:0] blk, input logic [7:0] dd,
                                input logic [7:0] sd, input int nk);
        logic [7:0] seg;
        logic [7:0] off;
        int  w;
        bit  cut;
        seg = blk >> 1;
        off = blk[0] ? 8'd128 : 8'd0;
        w   = 0;
        cut = 0;
        nack_at = nk;
        wr_idx  = 0;
        exp_q.push_back({1'b0, 2'd0, 8'h00});
        if (seg != 0) begin
            exp_q.push_back({1'b0, 2'd1, sd});  if (w++ == nk) cut = 1;
            if (!cut) begin exp_q.push_back({1'b0, 2'd1, seg}); if (w++ == nk) cut = 1; end
            if (!cut) exp_q.push_back({1'b0, 2'd0, 8'h00});
        end
        if (!cut) begin exp_q.push_back({1'b0, 2'd1, dd});  if (w++ == nk) cut = 1; end
        if (!cut) begin exp_q.push_back({1'b0, 2'd1, off}); if (w++ == nk) cut = 1; end
        if (!cut) exp_q.push_back({1'b0, 2'd0, 8'h00});
        if (!cut) begin exp_q.push_back({1'b0, 2'd1, dd | 8'h01}); if (w++ == nk) cut = 1; end
        if (!cut) begin
            for (int i = 0; i < 128; i++) exp_q.push_back({(i == 127), 2'd2, 8'h00});
        end
        exp_q.push_back({1'b0, 2'd3, 8'h00});
    endtask

    // start a fetch and poll the done flag; returns cycles spent
    task automatic run_fetch(input logic [7:0] blk, output int cyc);
        logic [7:0] f;
        reg_write(8'h82, blk);
        reg_write(8'h80, 8'h01);
        reg_write(8'h80, 8'h00);
        cyc = 2;
        f = 8'h00;
        while (!f[1] && cyc < 3000) begin
            reg_read(8'h81, f);
            cyc++;
        end
    endtask

    task automatic check_buffer(input logic [7:0] seg, input logic [7:0] off, input string req);
        logic [7:0] v;
        for (int i = 0; i < 128; i++) begin
            reg_read(8'(i), v);
            check(v == edid_byte(seg, 8'(off + i)), req, v, edid_byte(seg, 8'(off + i)));
        end
    endtask

    // monitor and bus-side responder
    initial begin
        forever begin
            @(negedge clk);
            i2c_rsp_valid = 1'b0;
            i2c_rsp_nack  = 1'b0;
            if (i2c_cmd_valid) begin
                logic [10:0] got;
                got = {i2c_cmd_nack, i2c_cmd_op, (i2c_cmd_op == 2'd1) ? i2c_cmd_data : 8'h00};
                cmd_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 or R5 or R9 unexpected command", int'(got), 0);
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    check(got == e, "R4 or R5 command order", int'(got), int'(e));
                end
                pend_nack = 1'b0;
                pend_data = 8'h00;
                case (i2c_cmd_op)
                    2'd0: addr_phase = 1'b1;
                    2'd1: begin
                        if (wr_idx == nack_at) pend_nack = 1'b1;
                        wr_idx++;
                        if (addr_phase) begin
                            cur_dev    = i2c_cmd_data;
                            addr_phase = 1'b0;
                            if (i2c_cmd_data != m_seg_dev && i2c_cmd_data != m_data_dev &&
                                i2c_cmd_data != (m_data_dev | 8'h01)) pend_nack = 1'b1;
                        end else if (cur_dev == m_seg_dev) begin
                            seg_ptr = i2c_cmd_data;
                        end else if (cur_dev == m_data_dev) begin
                            offs = i2c_cmd_data;
                        end
                    end
                    2'd2: begin
                        pend_data = edid_byte(seg_ptr, offs);
                        offs      = offs + 8'd1;
                    end
                    default: seg_ptr = 8'h00;
                endcase
                pend = 1'b1;
            end else if (pend) begin
                i2c_rsp_valid = 1'b1;
                i2c_rsp_nack  = pend_nack;
                i2c_rsp_data  = pend_data;
                pend          = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int cyc;
        int base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        reg_read(8'h83, v); check(v == 8'hA0, "R1 data device default", v, 8'hA0);
        reg_read(8'h84, v); check(v == 8'h60, "R1 segment device default", v, 8'h60);
        reg_read(8'h80, v); check(v == 8'h00, "R1 control reset", v, 0);
        reg_read(8'h81, v); check(v == 8'h00, "R1 flags reset", v, 0);

        // block 0: segment 0, even offset, no segment write
        expect_fetch(8'd0, 8'hA0, 8'h60, -1);
        reg_write(8'h82, 8'd0);
        reg_write(8'h80, 8'h01);
        reg_read(8'h81, v); check(v[0] == 1'b1, "R2 busy while fetching", v, 1);
        reg_write(8'h80, 8'h00);
        cyc = 0;
        while (!v[1] && cyc < 3000) begin reg_read(8'h81, v); cyc++; end
        check(v == 8'h02, "R7 done flag set, no error", v, 8'h02);
        check(exp_q.size() == 0, "R4 full sequence consumed", exp_q.size(), 0);
        check_buffer(8'd0, 8'd0, "R6 R3 block 0 contents");

        // R7 sticky, write 1 does not set, write 0 clears
        repeat (40) @(negedge clk);
        reg_read(8'h81, v); check(v == 8'h02, "R7 done stays set", v, 8'h02);
        reg_write(8'h81, 8'h02);
        reg_read(8'h81, v); check(v == 8'h02, "R7 writing 1 keeps done", v, 8'h02);
        reg_write(8'h81, 8'h00);
        reg_read(8'h81, v); check(v == 8'h00, "R7 writing 0 clears done", v, 0);
        reg_write(8'h81, 8'h06);
        reg_read(8'h81, v); check(v == 8'h00, "R7 writing 1 does not set", v, 0);

        // block 1: odd offset in segment 0
        expect_fetch(8'd1, 8'hA0, 8'h60, -1);
        run_fetch(8'd1, cyc);
        reg_read(8'h81, v); check(v == 8'h02, "R3 block 1 completes", v, 8'h02);
        check_buffer(8'd0, 8'd128, "R3 block 1 odd offset");
        reg_write(8'h81, 8'h00);

        // block 5: segment 2, odd offset, segment write first; R11 bound
        expect_fetch(8'd5, 8'hA0, 8'h60, -1);
        base = cmd_seen;
        run_fetch(8'd5, cyc);
        check(cmd_seen - base == 137, "R11 command count", cmd_seen - base, 137);
        check(cyc <= 3 * 137 + 12, "R11 completion cycles", cyc, 3 * 137 + 12);
        check(exp_q.size() == 0, "R5 segment sequence consumed", exp_q.size(), 0);
        check_buffer(8'd2, 8'd128, "R5 R3 block 5 contents");
        reg_write(8'h81, 8'h00);

        // R9 second start while busy, with block number changed
        expect_fetch(8'd4, 8'hA0, 8'h60, -1);
        base = cmd_seen;
        reg_write(8'h82, 8'd4);
        reg_write(8'h80, 8'h01);
        repeat (20) @(negedge clk);
        reg_write(8'h82, 8'd6);
        reg_write(8'h80, 8'h00);
        reg_write(8'h80, 8'h01);
        v = 8'h00;
        cyc = 0;
        while (!v[1] && cyc < 3000) begin reg_read(8'h81, v); cyc++; end
        repeat (30) @(negedge clk);
        check(cmd_seen - base == 137, "R9 no extra commands", cmd_seen - base, 137);
        check(exp_q.size() == 0, "R9 sequence of first start only", exp_q.size(), 0);
        check_buffer(8'd2, 8'd0, "R9 latched block 4 contents");
        reg_write(8'h80, 8'h00);
        reg_write(8'h81, 8'h00);

        // R10 programmed device addresses, block 3
        m_data_dev = 8'hA8;
        m_seg_dev  = 8'h64;
        reg_write(8'h83, 8'hA8);
        reg_write(8'h84, 8'h64);
        expect_fetch(8'd3, 8'hA8, 8'h64, -1);
        run_fetch(8'd3, cyc);
        reg_read(8'h81, v); check(v == 8'h02, "R10 fetch with new addresses", v, 8'h02);
        check_buffer(8'd1, 8'd128, "R10 block 3 contents");
        m_data_dev = 8'hA0;
        m_seg_dev  = 8'h60;
        reg_write(8'h83, 8'hA0);
        reg_write(8'h84, 8'h60);
        reg_write(8'h81, 8'h00);

        // R8 refusal on the segment value byte
        expect_fetch(8'd2, 8'hA0, 8'h60, 1);
        run_fetch(8'd2, cyc);
        reg_read(8'h81, v); check(v == 8'h06, "R8 error and done flags", v, 8'h06);
        check(exp_q.size() == 0, "R8 stop follows refusal", exp_q.size(), 0);
        check_buffer(8'd1, 8'd128, "R8 buffer unchanged");
        reg_write(8'h81, 8'h02);
        reg_read(8'h81, v); check(v == 8'h02, "R8 error cleared by writing 0", v, 8'h02);
        reg_write(8'h81, 8'h00);

        // R8 refusal on the read address byte, segment 0
        expect_fetch(8'd0, 8'hA0, 8'h60, 2);
        run_fetch(8'd0, cyc);
        reg_read(8'h81, v); check(v == 8'h06, "R8 refusal on read address", v, 8'h06);
        check(exp_q.size() == 0, "R8 stop after read address", exp_q.size(), 0);
        reg_read(8'h05, v); check(v == edid_byte(8'd1, 8'd133), "R8 buffer kept", v, edid_byte(8'd1, 8'd133));

        repeat (10) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule